// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block sits beside a small 8-bit processor core and decides which interrupt the core serves next. It has one reset source and 25 peripheral request flags. The reset source always wins. Among the peripheral flags, the lowest index wins. The block registers the program-memory word address of the winning vector, raises a take request, and holds both until the core accepts. When the core accepts a peripheral interrupt, the block acknowledges that single source so its pending flag can be cleared. In the same cycle it tells the core to clear its global interrupt enable.

Each vector is two words long. By default the table starts at word 0. One configuration bit moves all peripheral vectors to the start of a boot section at the top of the 16K-word program space. A separate bit sends reset to that same boot start. A 2-bit code selects the boot-section size, and the boot start depends on that size.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Peripheral flag `pend_i[i]` owns vector slot i+2, whose word offset is 2*(i+1) (index 0 at offset 0x02, index 24 at offset 0x32). The reset slot has offset 0.
- R2: Among pending peripheral flags, the lowest index is chosen.
- R3: A peripheral flag is never taken while `gie_i` is 0. A flag held while `gie_i` is 0 is taken once `gie_i` returns to 1, and several such flags are served one at a time, lowest index first.
- R4: `rst_req_i` is taken whether `gie_i` is 0 or 1, and it beats every peripheral flag.
- R5: The reset vector is 0x0000 when `rst_redir_i` is 0 and the boot start when it is 1, whatever the value of `vec_reloc_i`.
- R6: Peripheral vectors are at offset + 0x0000 when `vec_reloc_i` is 0 and at boot start + offset when it is 1, whatever the value of `rst_redir_i`.
- R7: `boot_sz_i` code k selects a boot size of 256<<k words (0:256, 1:512, 2:1024, 3:2048). The boot start is 0x4000 minus that size.
- R8: `take_o` and `vec_addr_o` are registered. They update at the first clock edge where the controller is idle and a request qualifies. While `take_o` is 1 and `accept_i` is 0, `take_o` stays 1 and `vec_addr_o` does not change, even if the inputs change.
- R9: In a cycle with `take_o` and `accept_i` both high for a peripheral vector, `ack_o` is one-hot on the chosen index and `gie_clr_o` is 1. For a reset vector both stay 0. `take_o` is 0 after that edge.
- R10: After reset is released, `take_o`, `ack_o` and `gie_clr_o` are 0 and `vec_addr_o` is 0x0000.
- R11: With no peripheral flag set and `rst_req_i` low, `take_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Reset-source request (slot 1) |
| pend_i | input | 25 | Peripheral pending flags, index 0 highest priority |
| gie_i | input | 1 | Global interrupt enable |
| vec_reloc_i | input | 1 | Move peripheral vectors to boot start |
| rst_redir_i | input | 1 | Send reset to boot start |
| boot_sz_i | input | 2 | Boot-section size code |
| accept_i | input | 1 | Core takes the offered vector |
| take_o | output | 1 | Take-interrupt request to core |
| vec_addr_o | output | 14 | Word address of the offered vector |
| ack_o | output | 25 | One-hot acknowledge to clear the served flag |
| gie_clr_o | output | 1 | Clear the global enable |

## Verification
The assertions assume that `accept_i` is high only in a cycle where `take_o` is already high. They also assume that a peripheral drops its flag once it sees its acknowledge, so the same source is not offered again for an interrupt that was already served. The bench follows both rules. It raises `accept_i` only after it has seen `take_o`, and it acts as the peripheral by clearing each acknowledged flag before the next edge. All inputs change on the falling clock edge, so every sample falls between registered updates.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned NUM_SRC_D   = 25;
  localparam int unsigned ADDR_W_D    = 14;
  localparam int unsigned MEM_WORDS_D = 16384;
  localparam int unsigned BOOT_MIN_D  = 256;
  localparam int unsigned VEC_WORDS_D = 2;

  // boot start = top of memory minus (minimum size << code)
  function automatic logic [31:0] boot_base(input logic [1:0] sz_code,
                                            input int unsigned mem_words,
                                            input int unsigned boot_min);
    logic [31:0] sz;
    sz = 32'(boot_min) << sz_code;
    return 32'(mem_words) - sz;
  endfunction
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N     = 25,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign seen[g+1]  = seen[g] | req_i[g];
    assign grant_o[g] = req_i[g] & ~seen[g];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  always_comb begin
    assert ($onehot0(grant_o)); // R2
  end
endmodule

// File: rtl/irq_vec_calc.sv
module irq_vec_calc
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_SRC   = NUM_SRC_D,
  parameter int unsigned ADDR_W    = ADDR_W_D,
  parameter int unsigned MEM_WORDS = MEM_WORDS_D,
  parameter int unsigned BOOT_MIN  = BOOT_MIN_D,
  parameter int unsigned VEC_WORDS = VEC_WORDS_D,
  parameter int unsigned SRC_W     = $clog2(NUM_SRC)
) (
  input  logic              is_rst_i,
  input  logic [SRC_W-1:0]  idx_i,
  input  logic              reloc_i,
  input  logic              redir_i,
  input  logic [1:0]        bsz_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [31:0] base_boot;
  logic [31:0] base;
  logic [31:0] offs;

  always_comb begin
    base_boot = boot_base(bsz_i, MEM_WORDS, BOOT_MIN);
    if (is_rst_i) begin
      base = redir_i ? base_boot : 32'd0;
      offs = 32'd0;
    end else begin
      base = reloc_i ? base_boot : 32'd0;
      offs = (32'(idx_i) + 32'd1) * 32'(VEC_WORDS);
    end
    addr_o = ADDR_W'(base + offs);
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_SRC   = NUM_SRC_D,
  parameter int unsigned ADDR_W    = ADDR_W_D,
  parameter int unsigned MEM_WORDS = MEM_WORDS_D,
  parameter int unsigned BOOT_MIN  = BOOT_MIN_D,
  parameter int unsigned VEC_WORDS = VEC_WORDS_D
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rst_req_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               gie_i,
  input  logic               vec_reloc_i,
  input  logic               rst_redir_i,
  input  logic [1:0]         boot_sz_i,
  input  logic               accept_i,
  output logic               take_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic [NUM_SRC-1:0] ack_o,
  output logic               gie_clr_o
);
  localparam int unsigned SRC_W = $clog2(NUM_SRC);

  logic               any_pend;
  logic [NUM_SRC-1:0] grant;
  logic [SRC_W-1:0]   win_idx;
  logic [ADDR_W-1:0]  next_addr;
  logic               per_ok;
  logic               start;

  logic               take_q;
  logic               is_rst_q;
  logic [NUM_SRC-1:0] grant_q;
  logic [ADDR_W-1:0]  addr_q;

  irq_prio_pick #(.N(NUM_SRC), .IDX_W(SRC_W)) u_pick (
    .req_i   (pend_i),
    .any_o   (any_pend),
    .grant_o (grant),
    .idx_o   (win_idx)
  );

  irq_vec_calc #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS),
    .BOOT_MIN(BOOT_MIN), .VEC_WORDS(VEC_WORDS), .SRC_W(SRC_W)
  ) u_calc (
    .is_rst_i (rst_req_i),
    .idx_i    (win_idx),
    .reloc_i  (vec_reloc_i),
    .redir_i  (rst_redir_i),
    .bsz_i    (boot_sz_i),
    .addr_o   (next_addr)
  );

  assign per_ok = gie_i & any_pend;
  assign start  = ~take_q & (rst_req_i | per_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q   <= 1'b0;
      is_rst_q <= 1'b0;
      grant_q  <= '0;
      addr_q   <= '0;
    end else if (start) begin
      take_q   <= 1'b1;
      is_rst_q <= rst_req_i;
      grant_q  <= rst_req_i ? '0 : grant;
      addr_q   <= next_addr;
    end else if (take_q && accept_i) begin
      take_q   <= 1'b0;
    end
  end

  logic fire_per;
  assign fire_per   = take_q & accept_i & ~is_rst_q;
  assign take_o     = take_q;
  assign vec_addr_o = addr_q;
  assign ack_o      = fire_per ? grant_q : '0;
  assign gie_clr_o  = fire_per;

  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o)) else $error("ack not onehot"); // R9
  AST_ACK_ONLY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> (take_o && accept_i && gie_clr_o)) else $error("stray ack"); // R9
  AST_HOLD_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !accept_i) |=> (take_o && $stable(vec_addr_o))) else $error("vector moved"); // R8
  AST_MASKED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_o && !gie_i && !rst_req_i) |=> !take_o) else $error("masked take"); // R3
  AST_RST_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_o && rst_req_i) |=> (take_o && is_rst_q)) else $error("reset lost"); // R4
  AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && accept_i) |=> !take_o) else $error("take stuck"); // R9
  AST_EVEN_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !vec_addr_o[0]) else $error("odd vector"); // R1
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N = 25;

  typedef struct packed {
    logic        rst;
    logic        gie;
    logic        reloc;
    logic        redir;
    logic [1:0]  bsz;
    logic [24:0] pend;
    logic [7:0]  slot;   // 0 = no take, 1 = reset, n = pend index n-2
    logic [13:0] addr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,2'd0,25'h0000001, 8'd2,  14'h0002}, // R1
    '{1'b0,1'b1,1'b0,1'b0,2'd0,25'h1000000, 8'd26, 14'h0032}, // R1
    '{1'b0,1'b1,1'b0,1'b0,2'd0,25'h1000020, 8'd7,  14'h000C}, // R2
    '{1'b0,1'b0,1'b0,1'b0,2'd0,25'h0000008, 8'd0,  14'h0000}, // R3
    '{1'b1,1'b0,1'b0,1'b0,2'd0,25'h0000000, 8'd1,  14'h0000}, // R4
    '{1'b1,1'b1,1'b0,1'b1,2'd0,25'h0000001, 8'd1,  14'h3F00}, // R5
    '{1'b1,1'b1,1'b1,1'b0,2'd3,25'h0000004, 8'd1,  14'h0000}, // R5
    '{1'b0,1'b1,1'b1,1'b0,2'd0,25'h0000004, 8'd4,  14'h3F06}, // R6
    '{1'b0,1'b1,1'b1,1'b0,2'd1,25'h1000000, 8'd26, 14'h3E32}, // R7
    '{1'b0,1'b1,1'b1,1'b1,2'd2,25'h0000400, 8'd12, 14'h3C16}, // R7
    '{1'b0,1'b1,1'b1,1'b0,2'd3,25'h0000002, 8'd3,  14'h3804}, // R7
    '{1'b0,1'b1,1'b0,1'b1,2'd3,25'h0000002, 8'd3,  14'h0004}, // R6
    '{1'b1,1'b1,1'b0,1'b1,2'd3,25'h1FFFFFF, 8'd1,  14'h3800}  // R4
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_req = 0, gie = 0, reloc = 0, redir = 0, accept = 0;
  logic [1:0]  bsz = '0;
  logic [N-1:0] pend = '0;
  logic take, gie_clr;
  logic [13:0] vaddr;
  logic [N-1:0] ack;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rst_req_i(rst_req), .pend_i(pend),
    .gie_i(gie), .vec_reloc_i(reloc), .rst_redir_i(redir),
    .boot_sz_i(bsz), .accept_i(accept), .take_o(take),
    .vec_addr_o(vaddr), .ack_o(ack), .gie_clr_o(gie_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 take", take, 0);
    chk("R10 ack", ack, 0);
    chk("R10 gie_clr", gie_clr, 0);
    chk("R10 addr", vaddr, 0);
    gie = 1;
    repeat (3) cyc();
    chk("R11 idle no take", take, 0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      rst_req = TBL[k].rst; gie = TBL[k].gie; reloc = TBL[k].reloc;
      redir = TBL[k].redir; bsz = TBL[k].bsz; pend = TBL[k].pend;
      cyc();
      chk($sformatf("R8 take v%0d", k), take, TBL[k].slot != 0);
      if (TBL[k].slot != 0) begin
        chk($sformatf("R1/R5/R6/R7 addr v%0d", k), vaddr, TBL[k].addr);
        accept = 1; #1;
        chk($sformatf("R9 ack v%0d", k), ack,
            TBL[k].slot >= 2 ? (32'd1 << (TBL[k].slot - 2)) : 32'd0);
        chk($sformatf("R9 gie_clr v%0d", k), gie_clr, TBL[k].slot >= 2);
      end
      @(negedge clk);
      accept = 0; pend = '0; rst_req = 0;
      #1;
      chk($sformatf("R9 take drop v%0d", k), take, 0);
    end

    // R8 hold: higher-priority flag arrives while offer is waiting
    @(negedge clk);
    reloc = 0; redir = 0; bsz = 0; gie = 1; pend = 25'h0000100;
    cyc();
    chk("R8 first offer", vaddr, 14'h0012);
    pend = 25'h0000101; rst_req = 0;
    repeat (3) cyc();
    chk("R8 held take", take, 1);
    chk("R8 held addr", vaddr, 14'h0012);
    accept = 1; #1;
    chk("R9 ack held src", ack, 32'h100);
    @(negedge clk); accept = 0; pend = '0;
    cyc();

    // R3 latched while masked, then served in order
    gie = 0; pend = 25'h0000088;
    repeat (4) cyc();
    chk("R3 masked no take", take, 0);
    gie = 1;
    cyc();
    chk("R3 first served", vaddr, 14'h0008);
    accept = 1; #1;
    chk("R3 first ack", ack, 32'h8);
    @(negedge clk); accept = 0; pend = 25'h0000080;
    cyc();
    chk("R3 second take", take, 1);
    chk("R3 second served", vaddr, 14'h0010);
    accept = 1; #1;
    chk("R3 second ack", ack, 32'h80);
    @(negedge clk); accept = 0; pend = '0;
    cyc();

    // R4 reset under mask beats flags, no ack on accept
    gie = 0; pend = 25'h0000001; rst_req = 1;
    cyc();
    chk("R4 masked reset take", take, 1);
    chk("R4 reset addr", vaddr, 14'h0000);
    accept = 1; #1;
    chk("R9 reset no ack", ack, 0);
    chk("R9 reset no gie_clr", gie_clr, 0);
    @(negedge clk); accept = 0; rst_req = 0; pend = '0;
    repeat (3) cyc();
    chk("R11 quiet after", take, 0);

    finish_run();
  end
endmodule